// File: doc/BRIEF.md
# Bidirectional Shift Register with Parallel Load

A register of configurable width that carries out one of four operations at every rising clock edge. A two-bit mode code selects the operation: keep the contents, move them one place toward the most significant end, move them one place toward the least significant end, or take a new word from a parallel input. Each bit position has its own four-way selector. The selector chooses among the bit's present value, the value of the stage below it, the value of the stage above it, and the stage's parallel input bit. One mode decoder drives the selectors of all stages.

A separate serial input feeds each end of the register. The whole word appears on a parallel output. The two end bits are also brought out on their own pins, so the register can be chained serially in either direction. An active-low clear acts without the clock and forces every bit to zero.

Top module: `bidir_shreg`

## Requirements
- R1: With mode code 2'b00 on a clock edge, every bit of `q` keeps the value it had before that edge.
- R2: With mode code 2'b01 on a clock edge, `q[i]` takes the old `q[i-1]` for i ≥ 1, `q[0]` takes `ser_lo_in`, and the old `q[WIDTH-1]` is lost.
- R3: With mode code 2'b10 on a clock edge, `q[i]` takes the old `q[i+1]` for i < WIDTH-1, `q[WIDTH-1]` takes `ser_hi_in`, and the old `q[0]` is lost.
- R4: With mode code 2'b11 on a clock edge, `q` takes the value of `par_in`.
- R5: When `clr_n` goes low between clock edges, `q` becomes all zeros right away, without waiting for a clock edge. Out of reset, `q` is zero.
- R6: `ser_lo_out` always equals `q[0]`, and `ser_hi_out` always equals `q[WIDTH-1]`.
- R7: While `clr_n` is held low, clock edges leave `q` at zero whatever the mode code and the data inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all stages update on its rising edge |
| clr_n | input | 1 | Active-low clear that acts without the clock |
| mode | input | 2 | Operation code: 00 hold, 01 shift toward MSB, 10 shift toward LSB, 11 load |
| ser_lo_in | input | 1 | Serial bit that enters bit 0 on mode 01 |
| ser_hi_in | input | 1 | Serial bit that enters the top bit on mode 10 |
| par_in | input | WIDTH | Parallel data taken on mode 11 |
| q | output | WIDTH | Register contents |
| ser_lo_out | output | 1 | Copy of bit 0 |
| ser_hi_out | output | 1 | Copy of the top bit |

## Verification
The bench builds the register with WIDTH = 5 rather than the default of 4. An odd width puts three interior stages between the two end stages, and each interior stage has neighbours on both sides. With five bits, a run of five shifts empties the register completely through either end, and a new pattern fills it again from the serial input. The bench also keeps the and-or selector variant, the default. A check of every mode against its own model then covers all four legs of every stage's selector.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   typedef enum logic [1:0] {
      MODE_HOLD = 2'b00,
      MODE_SHL  = 2'b01,
      MODE_SHR  = 2'b10,
      MODE_LOAD = 2'b11
   } shmode_t;

   // positions in the one-hot stage select
   localparam int SEL_SELF = 0;
   localparam int SEL_LO   = 1;
   localparam int SEL_HI   = 2;
   localparam int SEL_PAR  = 3;
   localparam int SEL_W    = 4;
endpackage

// File: rtl/shreg_decode.sv
module shreg_decode
   import shreg_pkg::*;
(
   input  shmode_t           mode,
   output logic [SEL_W-1:0]  sel
);
   timeunit 1ns;
   timeprecision 1ps;

   always_comb begin
      sel = '0;
      unique case (mode)
         MODE_HOLD: sel[SEL_SELF] = 1'b1;
         MODE_SHL:  sel[SEL_LO]   = 1'b1;
         MODE_SHR:  sel[SEL_HI]   = 1'b1;
         MODE_LOAD: sel[SEL_PAR]  = 1'b1;
         default:   sel[SEL_SELF] = 1'b1;
      endcase
   end
endmodule

// File: rtl/shreg_stage.sv
module shreg_stage
   import shreg_pkg::*;
#(
   parameter bit ONEHOT_MUX = 1'b1
)(
   input  logic             clk,
   input  logic             clr_n,
   input  logic [SEL_W-1:0] sel,
   input  logic             d_lo,
   input  logic             d_hi,
   input  logic             d_par,
   output logic             q
);
   timeunit 1ns;
   timeprecision 1ps;

   logic nxt;

   generate
      if (ONEHOT_MUX) begin : g_andor
         // flat and-or: one gate level after the decoder
         assign nxt = |(sel & {d_par, d_hi, d_lo, q});
      end else begin : g_prio
         // priority chain: tolerates a select with more than one bit set
         always_comb begin
            if (sel[SEL_PAR])     nxt = d_par;
            else if (sel[SEL_HI]) nxt = d_hi;
            else if (sel[SEL_LO]) nxt = d_lo;
            else                  nxt = q;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) q <= 1'b0;
      else        q <= nxt;
   end
endmodule

// File: rtl/bidir_shreg.sv
module bidir_shreg
   import shreg_pkg::*;
#(
   parameter int WIDTH      = 4,
   parameter bit ONEHOT_MUX = 1'b1
)(
   input  logic             clk,
   input  logic             clr_n,
   input  logic [1:0]       mode,
   input  logic             ser_lo_in,
   input  logic             ser_hi_in,
   input  logic [WIDTH-1:0] par_in,
   output logic [WIDTH-1:0] q,
   output logic             ser_lo_out,
   output logic             ser_hi_out
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int MSB   = WIDTH - 1;
   localparam int EXT_W = WIDTH + 2;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("bidir_shreg: WIDTH must be at least 2");
      end
   endgenerate

   logic [SEL_W-1:0] sel_oh;
   logic [EXT_W-1:0] ext;   // serial inputs padded onto both ends of q

   shreg_decode u_dec (
      .mode (shmode_t'(mode)),
      .sel  (sel_oh)
   );

   assign ext = {ser_hi_in, q, ser_lo_in};

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         shreg_stage #(.ONEHOT_MUX(ONEHOT_MUX)) u_stage (
            .clk   (clk),
            .clr_n (clr_n),
            .sel   (sel_oh),
            .d_lo  (ext[i]),
            .d_hi  (ext[i+2]),
            .d_par (par_in[i]),
            .q     (q[i])
         );
      end
   endgenerate

   assign ser_lo_out = q[0];
   assign ser_hi_out = q[MSB];
endmodule

// File: rtl/shreg_chk.sv
module shreg_chk #(
   parameter int WIDTH = 4
)(
   input logic             clk,
   input logic             clr_n,
   input logic [1:0]       mode,
   input logic             ser_lo_in,
   input logic             ser_hi_in,
   input logic [WIDTH-1:0] par_in,
   input logic [WIDTH-1:0] q,
   input logic [3:0]       sel_oh
);
   timeunit 1ns;
   timeprecision 1ps;

   p_hold_r1: assert property (@(posedge clk) disable iff (!clr_n)
      mode == 2'b00 |=> q == $past(q));

   p_shl_r2: assert property (@(posedge clk) disable iff (!clr_n)
      mode == 2'b01 |=> q == {$past(q[WIDTH-2:0]), $past(ser_lo_in)});

   p_shr_r3: assert property (@(posedge clk) disable iff (!clr_n)
      mode == 2'b10 |=> q == {$past(ser_hi_in), $past(q[WIDTH-1:1])});

   p_load_r4: assert property (@(posedge clk) disable iff (!clr_n)
      mode == 2'b11 |=> q == $past(par_in));

   p_clear_r7: assert property (@(posedge clk)
      !clr_n |-> q == '0);

   // decoder feeds every stage a single-leg select (R1 to R4)
   p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!clr_n)
      $countones(sel_oh) == 1);
endmodule

bind bidir_shreg shreg_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .clr_n     (clr_n),
   .mode      (mode),
   .ser_lo_in (ser_lo_in),
   .ser_hi_in (ser_hi_in),
   .par_in    (par_in),
   .q         (q),
   .sel_oh    (sel_oh)
);

// File: tb/tb_bidir_shreg.sv
module tb_bidir_shreg;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int W = 5;

   typedef struct {
      logic [W-1:0] exp;
      string        tag;
   } item_t;

   logic         clk = 1'b0;
   logic         clr_n = 1'b0;
   logic [1:0]   mode = 2'b00;
   logic         ser_lo_in = 1'b0;
   logic         ser_hi_in = 1'b0;
   logic [W-1:0] par_in = '0;
   logic [W-1:0] q;
   logic         ser_lo_out, ser_hi_out;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   item_t sb[$];
   logic [W-1:0] mdl = '0;

   always #4 clk = ~clk;   // 125 MHz

   bidir_shreg #(.WIDTH(W)) dut (
      .clk(clk), .clr_n(clr_n), .mode(mode),
      .ser_lo_in(ser_lo_in), .ser_hi_in(ser_hi_in), .par_in(par_in),
      .q(q), .ser_lo_out(ser_lo_out), .ser_hi_out(ser_hi_out)
   );

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   // driver: apply one operation and queue its expected result
   task automatic step(input logic [1:0] m, input logic sl, input logic sr, input logic [W-1:0] p);
      item_t it;
      @(negedge clk);
      mode = m; ser_lo_in = sl; ser_hi_in = sr; par_in = p;
      case (m)
         2'b00: begin mdl = mdl;                    it.tag = "R1 hold"; end
         2'b01: begin mdl = {mdl[W-2:0], sl};       it.tag = "R2 shift-left"; end
         2'b10: begin mdl = {sr, mdl[W-1:1]};       it.tag = "R3 shift-right"; end
         default: begin mdl = p;                    it.tag = "R4 load"; end
      endcase
      if (!clr_n) begin
         mdl = '0;
         it.tag = "R7 clear-held";
      end
      it.exp = mdl;
      sb.push_back(it);
   endtask

   // monitor: compare after each edge, away from it
   initial begin
      forever begin
         item_t it;
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            it = sb.pop_front();
            check(it.tag, q, it.exp);
            check("R6 serial outputs", {{(W-2){1'b0}}, ser_hi_out, ser_lo_out},
                  {{(W-2){1'b0}}, it.exp[W-1], it.exp[0]});
         end
      end
   end

   task automatic drain();
      while (sb.size() > 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R5 reset state", q, '0);
      clr_n = 1'b1;

      step(2'b11, 0, 0, 5'b10110);
      step(2'b00, 1, 1, 5'b01001);
      step(2'b00, 0, 0, 5'b11111);
      step(2'b01, 1, 0, 5'b00000);
      step(2'b01, 0, 1, 5'b00000);
      step(2'b10, 0, 1, 5'b00000);
      step(2'b10, 1, 0, 5'b00000);
      step(2'b11, 0, 0, 5'b11111);
      for (int k = 0; k < W; k++) step(2'b01, 0, 1, 5'b10101);
      for (int k = 0; k < W; k++) step(2'b10, 1, 0, 5'b01010);
      step(2'b11, 0, 0, 5'b10001);
      for (int k = 0; k < W; k++) step(2'b10, 0, 0, 5'b11111);
      for (int k = 0; k < 60; k++)
         step(2'($urandom_range(3)), 1'($urandom_range(1)),
              1'($urandom_range(1)), W'($urandom_range(31)));
      step(2'b11, 0, 0, 5'b11011);
      drain();

      // clear between edges acts at once
      @(posedge clk);
      #3 clr_n = 1'b0;
      #1 check("R5 clear without clock", q, '0);
      mdl = '0;
      step(2'b11, 1, 1, 5'b11111);
      step(2'b01, 1, 1, 5'b11111);
      step(2'b10, 1, 1, 5'b11111);
      drain();
      @(negedge clk) clr_n = 1'b1;
      step(2'b01, 1, 0, 5'b00000);
      step(2'b10, 0, 1, 5'b00000);
      drain();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got hang expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule